// File: doc/BRIEF.md
# Descriptor Chain Walker for Scatter-Gather Transfers

This block follows a linked list of 16-byte transfer descriptors held in external memory. Software places a chain in memory and pulses `start` with the address of the first entry. The walker reads each entry over a read-request / read-response pair of valid/ready streams. It decodes the buffer address, the length, the direction and the transfer mode, and hands one request to an external data mover over a valid/ready stream. It then waits for the mover's `xfer_done` pulse. Only after that pulse does it follow the entry's next pointer.

The walk ends in one of three ways. An entry whose end flag is set finishes the walk, and `walk_done` pulses. A descriptor pointer that is not 8-byte aligned stops the walk with an alignment error. An entry with a zero length stops the walk with a length error, and no request is issued for that entry. Only one entry is in flight at a time.

On every stream the sender holds valid, and all fields stable, until the cycle in which ready is high. A beat moves on the rising edge where both valid and ready are high. The walker asserts `mrsp_ready` only while it is gathering an entry, so the memory may stall for any number of cycles. The mover may stall `xfer_ready` for any number of cycles. `ADDR_W` must not exceed 32, and `DATA_W` must divide 128.

Top module: `sgw_chain_walker`

## Requirements
- R1: After reset `busy`, `mrd_valid`, `mrsp_ready`, `xfer_valid`, `walk_done` and `walk_err` are 0, and `err_kind` is 0. While `busy` is 0, no stream valid or ready output is high.
- R2: A `start` pulse while idle with an 8-byte aligned `head_ptr` raises `mrd_valid` in the next cycle, with `mrd_addr` equal to `head_ptr`. `mrd_valid` and `mrd_addr` hold until `mrd_ready`. The entry then returns as 128/`DATA_W` response beats, and beat i carries entry bytes starting at i*`DATA_W`/8, little-endian.
- R3: The transfer request carries the following fields:
  - `xfer_addr` is entry bytes 0–3.
  - `xfer_bytes` is the 32-bit length in bytes 4–7 shifted left by 3.
  - `xfer_write` is bit 5 of byte 8.
  - `xfer_mode` is the low 4 bits of byte 9.
  All fields hold with `xfer_valid` until `xfer_ready`.
- R4: After a request is accepted, nothing else happens until an `xfer_done` pulse arrives. An `xfer_done` at any other time has no effect.
- R5: When the entry whose byte 8 bit 7 (end) is set completes, `walk_done` pulses for exactly one cycle and the walker goes idle. That entry's next field (bytes 12–15) is ignored, even if it is misaligned.
- R6: A misaligned pointer stops the walk: `walk_err` pulses, `err_kind` becomes 1 and holds, and no fetch is made at that pointer. A pointer is misaligned when any of its low 3 bits is nonzero. Both the start pointer and a followed next pointer are checked.
- R7: An entry with a zero length field stops the walk with a `walk_err` pulse and `err_kind` = 2, and no transfer request is made for it.
- R8: `start` has no effect while `busy` is 1.
- R9: For a completed entry without the end flag, the next fetch address is bytes 12–15 of that entry.
- R10: Byte 8 bit 4 (ordering), byte 10 and byte 11 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| head_ptr | input | ADDR_W | Address of the first entry |
| busy | output | 1 | A walk is in progress |
| mrd_valid | output | 1 | Entry read request valid |
| mrd_ready | input | 1 | Memory accepts the read request |
| mrd_addr | output | ADDR_W | Byte address of the entry to read |
| mrsp_valid | input | 1 | Response beat valid |
| mrsp_ready | output | 1 | Walker accepts a response beat |
| mrsp_data | input | DATA_W | Response beat data |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Mover accepts the request |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_bytes | output | 35 | Transfer length in bytes |
| xfer_write | output | 1 | 1 = outbound (write to disk) |
| xfer_mode | output | 4 | Transfer mode |
| xfer_done | input | 1 | Mover finished the accepted request |
| walk_done | output | 1 | One-cycle pulse: chain finished |
| walk_err | output | 1 | One-cycle pulse: walk stopped on an error |
| err_kind | output | 2 | Last error: 1 alignment, 2 zero length |

## Verification
The bench builds the walker with `ADDR_W` = 32 and `DATA_W` = 32, so each entry arrives as four response beats. This brings the beat order and the byte positions of every field into reach, along with a 35-bit byte length whose top bits come only from the shift. Full 32-bit pointers let chains jump backward and forward through memory. Misaligned next pointers can also be placed in end entries, where they must be ignored. Stall patterns on all three streams, start pulses during a walk and stray done pulses are run against a behavioural per-cycle model.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  // Entry geometry (fixed by the descriptor layout in memory)
  localparam int DESC_BYTES = 16;
  localparam int DESC_BITS  = DESC_BYTES * 8;
  localparam int LEN_W      = 32;
  localparam int LEN_SHIFT  = 3;
  localparam int MODE_W     = 4;
  localparam int ALIGN_BITS = 3;

  // Bit positions inside the flattened little-endian entry
  localparam int BUF_LSB    = 0;
  localparam int LEN_LSB    = 32;
  localparam int FLAG_LSB   = 64;
  localparam int FLAG_WRITE = 5;
  localparam int FLAG_END   = 7;
  localparam int MODE_LSB   = 72;
  localparam int NEXT_LSB   = 96;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_VET, ST_ISSUE, ST_WAIT
  } walk_st_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_LEN   = 2'd2
  } walk_err_t;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic [ADDR_W-1:0]    launch_addr,
  output logic                 mrd_valid,
  input  logic                 mrd_ready,
  output logic [ADDR_W-1:0]    mrd_addr,
  input  logic                 mrsp_valid,
  output logic                 mrsp_ready,
  input  logic [DATA_W-1:0]    mrsp_data,
  output logic [DESC_BITS-1:0] desc_raw,
  output logic                 fill_done
);
  localparam int BEATS = DESC_BITS / DATA_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              req_q;
  logic              gath_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  beat_q;
  logic              take;
  logic              last_beat;

  assign take      = gath_q & mrsp_valid;
  assign last_beat = (beat_q == CNT_W'(BEATS - 1));
  assign fill_done = take & last_beat;

  assign mrd_valid  = req_q;
  assign mrd_addr   = addr_q;
  assign mrsp_ready = gath_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      gath_q <= 1'b0;
      addr_q <= '0;
      beat_q <= '0;
    end else if (launch) begin
      req_q  <= 1'b1;
      addr_q <= launch_addr;
    end else if (req_q && mrd_ready) begin
      req_q  <= 1'b0;
      gath_q <= 1'b1;
      beat_q <= '0;
    end else if (take) begin
      beat_q <= beat_q + CNT_W'(1);
      if (last_beat) gath_q <= 1'b0;
    end
  end

  // One holding slot per response beat
  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               slot_q <= '0;
      else if (take && beat_q == CNT_W'(g))     slot_q <= mrsp_data;
    end
    assign desc_raw[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [DESC_BITS-1:0] desc_raw,
  output logic [ADDR_W-1:0]    buf_addr,
  output logic [LEN_W-1:0]     len_units,
  output logic                 is_write,
  output logic [MODE_W-1:0]    mode,
  output logic                 is_end,
  output logic [ADDR_W-1:0]    next_ptr,
  output logic                 len_zero,
  output logic                 next_misaligned
);
  logic unused_fields;

  assign buf_addr        = desc_raw[BUF_LSB +: ADDR_W];
  assign len_units       = desc_raw[LEN_LSB +: LEN_W];
  assign is_write        = desc_raw[FLAG_LSB + FLAG_WRITE];
  assign is_end          = desc_raw[FLAG_LSB + FLAG_END];
  assign mode            = desc_raw[MODE_LSB +: MODE_W];
  assign next_ptr        = desc_raw[NEXT_LSB +: ADDR_W];
  assign len_zero        = (len_units == '0);
  assign next_misaligned = |next_ptr[ALIGN_BITS-1:0];
  // ordering flag, word count and reserved byte are carried but not used
  assign unused_fields   = ^desc_raw;
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic              fill_done,
  input  logic              len_zero,
  input  logic              is_end,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic              next_misaligned,
  input  logic              xfer_ready,
  input  logic              xfer_done,
  output logic              launch,
  output logic [ADDR_W-1:0] launch_addr,
  output logic              busy,
  output logic              xfer_valid,
  output logic              walk_done,
  output logic              walk_err,
  output logic [1:0]        err_kind
);
  walk_st_t  st_q, st_d;
  walk_err_t kind_q, code_d;
  logic      done_q, err_q, done_d, err_d;

  always_comb begin
    st_d        = st_q;
    launch      = 1'b0;
    launch_addr = head_ptr;
    done_d      = 1'b0;
    err_d       = 1'b0;
    code_d      = ERR_NONE;
    case (st_q)
      ST_IDLE: if (start) begin
        if (|head_ptr[ALIGN_BITS-1:0]) begin
          err_d  = 1'b1;
          code_d = ERR_ALIGN;
        end else begin
          launch = 1'b1;
          st_d   = ST_FETCH;
        end
      end
      ST_FETCH: if (fill_done) st_d = ST_VET;
      ST_VET: begin
        if (len_zero) begin
          err_d  = 1'b1;
          code_d = ERR_LEN;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_ISSUE;
        end
      end
      ST_ISSUE: if (xfer_ready) st_d = ST_WAIT;
      ST_WAIT: if (xfer_done) begin
        if (is_end) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (next_misaligned) begin
          err_d  = 1'b1;
          code_d = ERR_ALIGN;
          st_d   = ST_IDLE;
        end else begin
          launch      = 1'b1;
          launch_addr = next_ptr;
          st_d        = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= ERR_NONE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (err_d) kind_q <= code_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign xfer_valid = (st_q == ST_ISSUE);
  assign walk_done  = done_q;
  assign walk_err   = err_q;
  assign err_kind   = kind_q;
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int XLEN_W = LEN_W + LEN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_ptr,
  output logic              busy,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [DATA_W-1:0] mrsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [XLEN_W-1:0] xfer_bytes,
  output logic              xfer_write,
  output logic [MODE_W-1:0] xfer_mode,
  input  logic              xfer_done,
  output logic              walk_done,
  output logic              walk_err,
  output logic [1:0]        err_kind
);
  logic                 launch;
  logic [ADDR_W-1:0]    launch_addr;
  logic [DESC_BITS-1:0] desc_raw;
  logic                 fill_done;
  logic [LEN_W-1:0]     len_units;
  logic                 is_end, len_zero, next_misaligned;
  logic [ADDR_W-1:0]    next_ptr;

  sgw_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fetch_i (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_addr(launch_addr),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .desc_raw(desc_raw), .fill_done(fill_done)
  );

  sgw_decode #(.ADDR_W(ADDR_W)) decode_i (
    .desc_raw(desc_raw),
    .buf_addr(xfer_addr), .len_units(len_units), .is_write(xfer_write),
    .mode(xfer_mode), .is_end(is_end), .next_ptr(next_ptr),
    .len_zero(len_zero), .next_misaligned(next_misaligned)
  );

  sgw_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .start(start), .head_ptr(head_ptr),
    .fill_done(fill_done), .len_zero(len_zero), .is_end(is_end),
    .next_ptr(next_ptr), .next_misaligned(next_misaligned),
    .xfer_ready(xfer_ready), .xfer_done(xfer_done),
    .launch(launch), .launch_addr(launch_addr),
    .busy(busy), .xfer_valid(xfer_valid),
    .walk_done(walk_done), .walk_err(walk_err), .err_kind(err_kind)
  );

  assign xfer_bytes = {len_units, {LEN_SHIFT{1'b0}}};
endmodule

// File: rtl/sgw_walker_checker.sv
module sgw_walker_checker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN_W = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mrd_valid,
  input logic              mrd_ready,
  input logic [ADDR_W-1:0] mrd_addr,
  input logic              mrsp_ready,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [XLEN_W-1:0] xfer_bytes,
  input logic              xfer_write,
  input logic [MODE_W-1:0] xfer_mode,
  input logic              walk_done,
  input logic              walk_err,
  input logic [1:0]        err_kind
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mrd_valid && !mrsp_ready && !xfer_valid));

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

  p_xfer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) &&
      $stable(xfer_bytes) && $stable(xfer_write) && $stable(xfer_mode)));

  p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mrd_valid, mrsp_ready, xfer_valid}));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  p_outcome_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done || walk_err) |-> (!busy && !(walk_done && walk_err)));

  p_fetch_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid |-> (mrd_addr[ALIGN_BITS-1:0] == '0));

  p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_bytes != '0));

  p_err_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |-> (err_kind != 2'd0));
endmodule

bind sgw_chain_walker sgw_walker_checker #(.ADDR_W(ADDR_W), .XLEN_W(XLEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
  .mrsp_ready(mrsp_ready),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
  .xfer_bytes(xfer_bytes), .xfer_write(xfer_write), .xfer_mode(xfer_mode),
  .walk_done(walk_done), .walk_err(walk_err), .err_kind(err_kind)
);

// File: tb/sgw_chain_walker_tb_top.sv
`timescale 1ns/1ps
module sgw_chain_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] head_ptr = '0;
  logic        busy, mrd_valid, mrsp_ready, xfer_valid, xfer_write;
  logic        walk_done, walk_err;
  logic        mrd_ready = 1'b0, mrsp_valid = 1'b0, xfer_ready = 1'b0, xfer_done = 1'b0;
  logic [31:0] mrd_addr, xfer_addr;
  logic [31:0] mrsp_data = '0;
  logic [34:0] xfer_bytes;
  logic [3:0]  xfer_mode;
  logic [1:0]  err_kind;

  always #4 clk = ~clk;  // 125 MHz

  sgw_chain_walker #(.ADDR_W(32), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr), .busy(busy),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_bytes(xfer_bytes), .xfer_write(xfer_write), .xfer_mode(xfer_mode),
    .xfer_done(xfer_done), .walk_done(walk_done), .walk_err(walk_err),
    .err_kind(err_kind)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rsp_q[$];
  int  mv_cnt = 0;
  bit  stall = 0, spur = 0, spam = 0, drv_start = 0;
  logic [31:0] drv_head = '0;
  logic [31:0] lg_addr[$];
  logic [34:0] lg_bytes[$];
  bit          lg_wr[$];
  logic [3:0]  lg_mode[$];
  int seen_done, seen_err, seen_fetch;
  logic [1:0] last_kind;

  // behavioural reference: 0 idle, 1 request, 2 gather, 3 vet, 4 issue, 5 wait
  int          m_ph = 0, m_beat = 0;
  logic [31:0] m_ptr = '0;
  logic [31:0] m_w [4];
  bit          m_done = 0, m_err = 0;
  logic [1:0]  m_kind = 2'd0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit d = 0, e = 0;
    case (m_ph)
      0: if (start) begin
           if (head_ptr[2:0] != 3'd0) begin e = 1; m_kind = 2'd1; end
           else begin m_ptr = head_ptr; m_ph = 1; end
         end
      1: if (mrd_ready) begin m_ph = 2; m_beat = 0; end
      2: if (mrsp_valid) begin
           m_w[m_beat] = mrsp_data;
           if (m_beat == 3) m_ph = 3; else m_beat++;
         end
      3: if (m_w[1] == 32'd0) begin e = 1; m_kind = 2'd2; m_ph = 0; end
         else m_ph = 4;
      4: if (xfer_ready) m_ph = 5;
      5: if (xfer_done) begin
           if (m_w[2][7]) begin d = 1; m_ph = 0; end
           else if (m_w[3][2:0] != 3'd0) begin e = 1; m_kind = 2'd1; m_ph = 0; end
           else begin m_ptr = m_w[3]; m_ph = 1; end
         end
      default: m_ph = 0;
    endcase
    m_done = d;
    m_err  = e;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    check("R1", "busy", 64'(busy), 64'(m_ph != 0));
    check("R2", "mrd_valid", 64'(mrd_valid), 64'(m_ph == 1));
    if (m_ph == 1) check("R2", "mrd_addr", 64'(mrd_addr), 64'(m_ptr));
    check("R2", "mrsp_ready", 64'(mrsp_ready), 64'(m_ph == 2));
    check("R4", "xfer_valid", 64'(xfer_valid), 64'(m_ph == 4));
    if (m_ph == 4) begin
      check("R3", "xfer_addr", 64'(xfer_addr), 64'(m_w[0]));
      check("R3", "xfer_bytes", 64'(xfer_bytes), 64'({m_w[1], 3'b000}));
      check("R3", "xfer_write", 64'(xfer_write), 64'(m_w[2][5]));
      check("R3", "xfer_mode", 64'(xfer_mode), 64'(m_w[2][11:8]));
    end
    check("R5", "walk_done", 64'(walk_done), 64'(m_done));
    check("R6", "walk_err", 64'(walk_err), 64'(m_err));
    check("R7", "err_kind", 64'(err_kind), 64'(m_kind));
    if (walk_done) seen_done++;
    if (walk_err) begin seen_err++; last_kind = err_kind; end
    if (mrd_valid) seen_fetch++;
    // drive inputs for the coming edge
    if (spam && busy) begin start = 1'b1; head_ptr = 32'h200; end
    else begin start = drv_start; head_ptr = drv_head; end
    mrd_ready  = stall ? (cyc % 3 != 0) : 1'b1;
    mrsp_valid = (rsp_q.size() > 0) && (stall ? (cyc % 2 == 0) : 1'b1);
    mrsp_data  = (rsp_q.size() > 0) ? rsp_q[0] : 32'd0;
    xfer_ready = stall ? (cyc % 4 == 3) : 1'b1;
    xfer_done  = (mv_cnt == 1) || (spur && mv_cnt == 0 && (cyc % 3 == 0));
    model_step();
    // environment bookkeeping for handshakes at the coming edge
    if (mrsp_valid && mrsp_ready) void'(rsp_q.pop_front());
    if (mrd_valid && mrd_ready)
      for (int i = 0; i < 4; i++) rsp_q.push_back(mem[int'(mrd_addr[9:2]) + i]);
    if (mv_cnt > 0) mv_cnt--;
    if (xfer_valid && xfer_ready) begin
      lg_addr.push_back(xfer_addr);
      lg_bytes.push_back(xfer_bytes);
      lg_wr.push_back(xfer_write);
      lg_mode.push_back(xfer_mode);
      mv_cnt = 3;
    end
  endtask

  task automatic put_desc(input int addr, input logic [31:0] bufa, input logic [31:0] len,
                          input logic [7:0] flags, input logic [7:0] mode_b,
                          input logic [7:0] b10, input logic [31:0] nxt);
    int idx = addr >> 2;
    mem[idx]     = bufa;
    mem[idx + 1] = len;
    mem[idx + 2] = {8'hC3, b10, mode_b, flags};
    mem[idx + 3] = nxt;
  endtask

  task automatic run_walk(input logic [31:0] head);
    lg_addr.delete(); lg_bytes.delete(); lg_wr.delete(); lg_mode.delete();
    seen_done = 0; seen_err = 0; seen_fetch = 0; last_kind = 2'd0;
    drv_start = 1; drv_head = head;
    tick();
    drv_start = 0;
    for (int k = 0; k < 2000 && m_ph != 0; k++) tick();
    repeat (3) tick();
  endtask

  task automatic check_xfer(string req, int n, logic [31:0] a, logic [34:0] b,
                            bit w, logic [3:0] md);
    if (lg_addr.size() > n) begin
      check(req, "logged addr", 64'(lg_addr[n]), 64'(a));
      check(req, "logged bytes", 64'(lg_bytes[n]), 64'(b));
      check(req, "logged write", 64'(lg_wr[n]), 64'(w));
      check(req, "logged mode", 64'(lg_mode[n]), 64'(md));
    end else check(req, "missing transfer", 64'(lg_addr.size()), 64'(n + 1));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    // chain A -> B -> C, non-contiguous, backward jump
    put_desc(32'h040, 32'h1234_5000, 32'd4,         8'h30, 8'hA6, 8'h00, 32'h100);
    put_desc(32'h100, 32'h0000_8008, 32'h2000_0001, 8'h10, 8'h02, 8'h5A, 32'h0A8);
    put_desc(32'h0A8, 32'hDEAD_BEE8, 32'd1,         8'hA0, 8'h0F, 8'h00, 32'h0);
    // single end entry with a misaligned next field
    put_desc(32'h200, 32'h0000_0010, 32'd2,         8'h80, 8'h01, 8'h00, 32'h13);
    // zero-length second entry
    put_desc(32'h300, 32'h0000_4000, 32'd3,         8'h00, 8'h05, 8'h00, 32'h320);
    put_desc(32'h320, 32'h0000_5000, 32'd0,         8'h80, 8'h05, 8'h00, 32'h0);
    // misaligned next pointer on a non-end entry
    put_desc(32'h340, 32'h0000_6000, 32'd8,         8'h20, 8'h03, 8'h00, 32'h34C);

    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 64'(busy), 64'd0);
    check("R1", "valids in reset", 64'({mrd_valid, mrsp_ready, xfer_valid}), 64'd0);
    check("R1", "pulses in reset", 64'({walk_done, walk_err}), 64'd0);
    check("R1", "err_kind in reset", 64'(err_kind), 64'd0);
    rst_n = 1'b1;
    repeat (3) tick();

    // S1: three-entry chain under stalls (R2 R3 R9 R10)
    stall = 1;
    run_walk(32'h040);
    check("R9", "chain transfer count", 64'(lg_addr.size()), 64'd3);
    check_xfer("R3", 0, 32'h1234_5000, 35'd32, 1'b1, 4'd6);
    check_xfer("R10", 1, 32'h0000_8008, 35'h1_0000_0008, 1'b0, 4'd2);
    check_xfer("R5", 2, 32'hDEAD_BEE8, 35'd8, 1'b1, 4'd15);
    check("R5", "chain done pulses", 64'(seen_done), 64'd1);
    check("R6", "chain errors", 64'(seen_err), 64'd0);

    // S2: end entry ignores a misaligned next field (R5)
    stall = 0;
    run_walk(32'h200);
    check("R5", "single transfers", 64'(lg_addr.size()), 64'd1);
    check_xfer("R3", 0, 32'h10, 35'd16, 1'b0, 4'd1);
    check("R5", "single done", 64'(seen_done), 64'd1);
    check("R5", "single no error", 64'(seen_err), 64'd0);

    // S3: misaligned head (R6)
    run_walk(32'h204);
    check("R6", "head err pulse", 64'(seen_err), 64'd1);
    check("R6", "head err kind", 64'(last_kind), 64'd1);
    check("R6", "head no fetch", 64'(seen_fetch), 64'd0);
    check("R6", "head no transfer", 64'(lg_addr.size()), 64'd0);

    // S4: zero length stops the walk (R7)
    run_walk(32'h300);
    check("R7", "zero-len transfers", 64'(lg_addr.size()), 64'd1);
    check("R7", "zero-len err", 64'(seen_err), 64'd1);
    check("R7", "zero-len kind", 64'(last_kind), 64'd2);
    check("R7", "zero-len no done", 64'(seen_done), 64'd0);

    // S5: misaligned next pointer (R6)
    stall = 1;
    run_walk(32'h340);
    check("R6", "next-ptr transfers", 64'(lg_addr.size()), 64'd1);
    check("R6", "next-ptr err", 64'(seen_err), 64'd1);
    check("R6", "next-ptr kind", 64'(last_kind), 64'd1);

    // S6: start while busy and stray done pulses are ignored (R8 R4)
    spam = 1; spur = 1;
    run_walk(32'h040);
    spam = 0; spur = 0;
    check("R8", "busy-start transfers", 64'(lg_addr.size()), 64'd3);
    check_xfer("R8", 0, 32'h1234_5000, 35'd32, 1'b1, 4'd6);
    check_xfer("R4", 2, 32'hDEAD_BEE8, 35'd8, 1'b1, 4'd15);
    check("R4", "stray-done done pulses", 64'(seen_done), 64'd1);
    check("R8", "busy-start err kind kept", 64'(err_kind), 64'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule